// File: doc/BRIEF.md
# Sequential Packet Buffer Access Port

This block gives a host processor byte-wide access to a 2048-byte packet buffer held in a synchronous single-port RAM. The host loads an 11-bit buffer pointer through two pointer registers, then moves bytes through a single data register. An optional step-on-access mode lets a whole packet be streamed in or out with repeated accesses to the data register, without reloading the pointer.

Direction is part of the pointer setup. When the read-direction bit is set, loading the low pointer byte starts a RAM read right away, so the data register already holds the addressed byte by the time the host reads it. Each further read in that direction fetches the next byte in the background. After a transfer the host can read the pointer back to learn how many bytes moved.

The host bus is a chip select with single-cycle read and write strobes, a 3-bit register offset and 8-bit data. Register reads are combinational. The RAM side issues at most one access per cycle, and read data returns one clock after the request.

Top module: `bufptr_port`

## Requirements
- R1: After reset the pointer is 000h, read direction and step mode are off, the data register holds 00h, and the RAM is not accessed until the host writes.
- R2: Offset 2 reads back as {read-direction bit 7, step-mode bit 6, pointer[10:8] in bits 2:0}. Offset 3 reads back as pointer[7:0]. A host write to either offset loads those same fields.
- R3: Bits 5:3 of offset 2 always read as zero, even after 1s are written to them.
- R4: With read direction off, a write to offset 4 writes the byte to the RAM at the pointer in the same cycle (ram_en and ram_we both high). With step mode on, the pointer then advances by one.
- R5: With read direction on, a write to offset 3 issues a RAM read at the newly loaded pointer. The fetched byte is in the data register two clock edges after that write, so the host must leave at least one idle cycle before reading offset 4.
- R6: Stepping from 7FFh wraps the pointer to 000h.
- R7: With step mode off, data accesses leave the pointer unchanged, and repeated reads return the byte at that same location.
- R8: With read direction on, a write to offset 4 is ignored: there is no RAM write and the pointer does not move.
- R9: With step mode off and read direction off, repeated writes to offset 4 all land on the same RAM location, and the last write wins.
- R10: With read direction and step mode on, a read of offset 4 returns the prefetched byte, advances the pointer, and fetches the byte at the new pointer, including across the 7FFh-to-000h wrap.
- R11: rdata is 00h when no read is active and for offsets other than 2, 3 and 4. If rd and wr are both high, the access is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 11 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid one cycle after a read request |

## Verification
The bench targets the following corner cases, and what a faulty design would show in each:
- **Wrap at the top of the buffer.** A wrong carry width would leave the pointer at 7FFh, or set a stray high bit, instead of reaching 000h. The wrap is exercised in both directions.
- **Prefetch address after a step.** A design that fetches the old pointer after stepping would return each byte twice. One that skips the fetch would leave the data register stale.
- **Direction-sensitive data writes.** Data writes in read direction are issued, and so are repeated accesses with stepping off. A design that ignores the direction would corrupt the buffer. One that steps anyway would scatter the bytes.
- **Undefined pointer bits.** The unused bits of the high pointer register are written with 1s, to catch a design that stores them.

// File: rtl/bufptr_port.sv
module bufptr_port #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata
);
  localparam int HIW = AW - DW;
  localparam int PADW = DW - 2 - HIW;

  logic [AW-1:0] ptr_q, ptr_inc, pf_addr;
  logic [DW-1:0] data_q;
  logic          mode_rd, autoinc, pf_pend;
  logic          wr_acc, rd_acc, hit_hi, hit_lo, hit_dat;
  logic          data_wr, data_rd, pf_lo, step;

  assign wr_acc  = cs & wr;
  assign rd_acc  = cs & rd & ~wr;
  assign hit_hi  = (addr == 3'd2);
  assign hit_lo  = (addr == 3'd3);
  assign hit_dat = (addr == 3'd4);

  assign data_wr = wr_acc & hit_dat & ~mode_rd;
  assign data_rd = rd_acc & hit_dat & mode_rd;
  assign pf_lo   = wr_acc & hit_lo & mode_rd;
  assign step    = (data_wr | data_rd) & autoinc;

  assign ptr_inc = ptr_q + 1'b1;
  assign pf_addr = pf_lo   ? {ptr_q[AW-1:DW], wdata} :
                   autoinc ? ptr_inc : ptr_q;

  assign ram_en    = data_wr | data_rd | pf_lo;
  assign ram_we    = data_wr;
  assign ram_addr  = data_wr ? ptr_q : pf_addr;
  assign ram_wdata = wdata;

  always_comb begin
    rdata = '0;
    if (rd_acc) begin
      case (addr)
        3'd2:    rdata = {mode_rd, autoinc, {PADW{1'b0}}, ptr_q[AW-1:DW]};
        3'd3:    rdata = ptr_q[DW-1:0];
        3'd4:    rdata = data_q;
        default: rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      mode_rd <= 1'b0;
      autoinc <= 1'b0;
      data_q  <= '0;
      pf_pend <= 1'b0;
    end else begin
      pf_pend <= data_rd | pf_lo;
      if (pf_pend) data_q <= ram_rdata;
      if (wr_acc && hit_hi) begin
        mode_rd           <= wdata[DW-1];
        autoinc           <= wdata[DW-2];
        ptr_q[AW-1:DW]    <= wdata[HIW-1:0];
      end
      if (wr_acc && hit_lo) ptr_q[DW-1:0] <= wdata;
      if (step) ptr_q <= ptr_inc;
    end
  end
endmodule

module bufptr_port_chk #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          rd,
  input logic          wr,
  input logic [2:0]    addr,
  input logic [DW-1:0] rdata,
  input logic          ram_en,
  input logic          ram_we,
  input logic [DW-1:0] ram_rdata,
  input logic [AW-1:0] ptr_q,
  input logic          mode_rd,
  input logic          autoinc,
  input logic [DW-1:0] data_q,
  input logic          pf_pend
);
  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_en); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 3'd4 && !mode_rd && autoinc) |=> ptr_q == AW'($past(ptr_q) + 1'b1)); // R6
  AST_HOLD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && (rd || wr) && addr == 3'd4 && !autoinc) |=> $stable(ptr_q)); // R7
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_pend |=> data_q == $past(ram_rdata)); // R5
  AST_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && !wr && addr == 3'd2) |-> rdata[5:3] == 3'b000); // R3
  AST_RDMODE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 3'd4 && mode_rd) |-> !ram_we); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |-> rdata == '0); // R11
endmodule

bind bufptr_port bufptr_port_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
  .rdata(rdata), .ram_en(ram_en), .ram_we(ram_we), .ram_rdata(ram_rdata),
  .ptr_q(ptr_q), .mode_rd(mode_rd), .autoinc(autoinc), .data_q(data_q),
  .pf_pend(pf_pend)
);

// File: tb/sim_bufptr_port.sv
`timescale 1ns/1ps
module sim_bufptr_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [7:0]  wdata = 8'd0;
  logic [7:0]  rdata;
  logic        ram_en, ram_we;
  logic [10:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = 8'd0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] mem [2048];
  logic [10:0] m_ptr;
  logic        m_rd, m_ai, m_pend;
  logic [7:0]  m_data, m_pval;

  always #2.5 clk = ~clk;

  bufptr_port u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  task automatic model_port(output logic en, output logic we,
                            output logic [10:0] a, output logic [7:0] rv);
    logic w, r;
    w = cs & wr;
    r = cs & rd & ~wr;
    en = 1'b0; we = 1'b0; a = '0; rv = 8'd0;
    if (w && addr == 3'd4 && !m_rd) begin
      en = 1'b1; we = 1'b1; a = m_ptr;
    end else if (w && addr == 3'd3 && m_rd) begin
      en = 1'b1; a = {m_ptr[10:8], wdata};
    end else if (r && addr == 3'd4 && m_rd) begin
      en = 1'b1; a = m_ai ? 11'((int'(m_ptr) + 1) % 2048) : m_ptr;
    end
    if (r) begin
      case (addr)
        3'd2: rv = {m_rd, m_ai, 3'b000, m_ptr[10:8]};
        3'd3: rv = m_ptr[7:0];
        3'd4: rv = m_data;
        default: rv = 8'd0;
      endcase
    end
  endtask

  always @(posedge clk) begin
    logic en, we; logic [10:0] a; logic [7:0] rv;
    if (!rst_n) begin
      m_ptr = '0; m_rd = 0; m_ai = 0; m_pend = 0; m_data = 0; m_pval = 0;
    end else begin
      model_port(en, we, a, rv);
      if (m_pend) m_data = m_pval;
      m_pend = 1'b0;
      if (en && we) mem[a] = wdata;
      if (en && !we) begin
        ram_rdata <= mem[a];
        m_pval = mem[a];
        m_pend = 1'b1;
      end
      if (cs && wr && addr == 3'd2) begin
        m_rd = wdata[7]; m_ai = wdata[6]; m_ptr[10:8] = wdata[2:0];
      end
      if (cs && wr && addr == 3'd3) m_ptr[7:0] = wdata;
      if (addr == 3'd4 && m_ai && ((cs && wr && !m_rd) || (cs && rd && !wr && m_rd)))
        m_ptr = 11'((int'(m_ptr) + 1) % 2048);
    end
  end

  always @(negedge clk) begin
    logic en, we; logic [10:0] a; logic [7:0] rv;
    #1;
    if (rst_n && !done) begin
      model_port(en, we, a, rv);
      checks++;
      if (ram_en !== en || (en && (ram_we !== we || ram_addr !== a)) ||
          (we && ram_wdata !== wdata)) begin
        errors++;
        $display("FAIL R5 lockstep RAM port: got en=%0b we=%0b a=%h exp en=%0b we=%0b a=%h",
                 ram_en, ram_we, ram_addr, en, we, a);
      end
      checks++;
      if (rdata !== rv) begin
        errors++;
        $display("FAIL R11 lockstep rdata: got %h exp %h", rdata, rv);
      end
    end
  end

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic host_wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic host_rd(logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    cs = 1; rd = 1; addr = a;
    #1 v = rdata;
    @(negedge clk);
    cs = 0; rd = 0;
  endtask

  task automatic expect_rd(logic [2:0] a, logic [7:0] exp, string tag);
    logic [7:0] v;
    host_rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 8'((i * 7 + 3) % 256);
    #20000;
    errors++;
    $display("FAIL watchdog: got hung run exp completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    checks++;
    if (ram_en !== 1'b0) begin
      errors++;
      $display("FAIL R1 ram_en after reset: got %b exp 0", ram_en);
    end
    expect_rd(3'd2, 8'h00, "R1 hi ptr after reset");
    expect_rd(3'd3, 8'h00, "R1 lo ptr after reset");
    expect_rd(3'd4, 8'h00, "R1 data after reset");
    expect_rd(3'd0, 8'h00, "R11 unused offset 0");
    expect_rd(3'd7, 8'h00, "R11 unused offset 7");

    host_wr(3'd2, 8'hFF);
    expect_rd(3'd2, 8'hC7, "R3 undefined hi bits zero");
    host_wr(3'd2, 8'h45);
    expect_rd(3'd2, 8'h45, "R2 hi readback");
    host_wr(3'd3, 8'h9A);
    expect_rd(3'd3, 8'h9A, "R2 lo readback");

    host_wr(3'd2, 8'h41);
    host_wr(3'd3, 8'h00);
    host_wr(3'd4, 8'h11);
    host_wr(3'd4, 8'h22);
    host_wr(3'd4, 8'h33);
    expect_rd(3'd3, 8'h03, "R4 count after three writes");
    expect_rd(3'd2, 8'h41, "R4 hi after writes");
    chk("R4 first byte stored", mem[11'h100], 8'h11);
    chk("R4 third byte stored", mem[11'h102], 8'h33);

    host_wr(3'd2, 8'hC1);
    host_wr(3'd3, 8'h00);
    expect_rd(3'd4, 8'h11, "R5 prefetch on lo write");
    expect_rd(3'd4, 8'h22, "R10 next byte");
    expect_rd(3'd4, 8'h33, "R10 third byte");
    expect_rd(3'd3, 8'h03, "R10 count after reads");

    host_wr(3'd2, 8'h02);
    host_wr(3'd3, 8'h10);
    host_wr(3'd4, 8'hAA);
    host_wr(3'd4, 8'hBB);
    chk("R9 last write wins", mem[11'h210], 8'hBB);
    chk("R9 next untouched", mem[11'h211], 8'((11'h211 * 7 + 3) % 256));
    expect_rd(3'd3, 8'h10, "R9 pointer held");

    host_wr(3'd2, 8'h82);
    host_wr(3'd3, 8'h10);
    expect_rd(3'd4, 8'hBB, "R7 first read");
    expect_rd(3'd4, 8'hBB, "R7 repeated read");
    expect_rd(3'd3, 8'h10, "R7 pointer held");

    host_wr(3'd4, 8'h55);
    chk("R8 no RAM write in read mode", mem[11'h210], 8'hBB);
    expect_rd(3'd3, 8'h10, "R8 pointer unchanged");
    expect_rd(3'd4, 8'hBB, "R8 data unchanged");

    host_wr(3'd2, 8'h47);
    host_wr(3'd3, 8'hFF);
    host_wr(3'd4, 8'h77);
    expect_rd(3'd2, 8'h40, "R6 hi after wrap");
    expect_rd(3'd3, 8'h00, "R6 lo after wrap");
    chk("R6 top byte stored", mem[11'h7FF], 8'h77);

    host_wr(3'd2, 8'hC7);
    host_wr(3'd3, 8'hFF);
    expect_rd(3'd4, 8'h77, "R10 byte at 7FF");
    expect_rd(3'd4, 8'h03, "R10 byte at 000 after wrap");
    expect_rd(3'd2, 8'hC0, "R10 hi after read wrap");
    expect_rd(3'd3, 8'h01, "R10 lo after read wrap");

    @(negedge clk);
    cs = 1; rd = 1; wr = 1; addr = 3'd3; wdata = 8'h5C;
    #1 chk("R11 rd+wr gives no read data", rdata, 8'h00);
    @(negedge clk);
    cs = 0; rd = 0; wr = 0;
    expect_rd(3'd3, 8'h5C, "R11 rd+wr acts as write");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule